// File: doc/BRIEF.md
# Teletext Broadcast Service Packet Extractor

This block sits behind a teletext byte deserialiser and pulls the programme-label and date/time payload out of the broadcast service packet. Each received byte arrives with a strobe, its position in the packet and a flag giving the packet's format. A separate end-of-packet strobe closes the line and decides whether the collected data is committed.

For a format-2 packet, every byte in the message window is protected by the teletext 8/4 Hamming code. The block corrects single-bit errors and keeps the four message bits of each byte. It rejects the whole line if any byte in the window cannot be corrected, or if a byte in the window never arrived. For a format-1 packet, the date/time bytes are captured exactly as they were received.

An accepted format-2 line updates its transfer register and pulls an active-low data-available line low. An accepted format-1 line updates its own transfer register quietly and leaves that line alone. While a host bus access is in progress, a line is never committed. The start of each new field releases the data-available line.

Top module: `ttx_pkt_extract`

## Requirements
- R1: After reset, `davn_n` is 1 and every byte of `f2_xfer` and `f1_xfer` reads 8'hFF.
- R2: The Hamming code works as follows. Codeword bit 0 is transmission bit 1. Message bits m0..m3 sit at codeword bits 1, 3, 5 and 7. A codeword is clean when all four odd-parity checks hold:
  - bits {0,1,5,7}
  - bits {1,2,3,7}
  - bits {1,3,4,5}
  - all eight bits

  On a committed format-2 line, the message nibble (m3..m0) of packet byte 13+k goes to `f2_xfer[4k+3:4k]`, for k from 0 to 12. Bits 55:52 read 4'hF.
- R3: A format-2 byte with exactly one flipped bit, in any of the 8 positions, is corrected. The line is committed with the original nibble.
- R4: A format-2 byte whose full-parity check holds while another check fails is uncorrectable. The whole line is then dropped: both transfer registers and `davn_n` keep their values.
- R5: On a committed format-1 line, packet byte 15+k is stored unchanged in `f1_xfer[8k+7:8k]`, for k from 0 to 6. `davn_n` and `f2_xfer` do not change.
- R6: Committing a format-2 line drives `davn_n` to 0 in the cycle after the `pkt_end` strobe.
- R7: A `field_start` pulse drives `davn_n` to 1 in the next cycle. If a format-2 commit falls in the same cycle, the commit wins and `davn_n` goes to 0.
- R8: If `bus_busy` is 1 when `pkt_end` is strobed, nothing is stored and `davn_n` keeps its value. The line's data is discarded.
- R9: A line with a byte of its window missing is dropped. Bytes whose index lies outside the window are ignored, even when they are uncorrectable.
- R10: The transfer registers change only in the cycle after a `pkt_end` strobe. Incoming bytes alone leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A packet byte is present this cycle |
| byte_idx | input | IDX_W | Index of the byte within the packet |
| byte_data | input | 8 | Received byte, bit 0 first on air |
| fmt2 | input | 1 | 1 = format-2 packet, 0 = format-1 packet |
| pkt_end | input | 1 | End of the current packet; commit point |
| bus_busy | input | 1 | Host bus access in progress; blocks commits |
| field_start | input | 1 | Start of a new field |
| f2_xfer | output | 8*((F2_COUNT+1)/2) | Packed format-2 message nibbles |
| f1_xfer | output | 8*F1_COUNT | Raw format-1 bytes |
| davn_n | output | 1 | Data available, active low |

## Verification
Some properties are checked on every cycle:
- `davn_n` only falls after a format-2 end strobe that no bus access blocked.
- `davn_n` rises after a field start.
- A blocked end strobe or a format-1 end strobe never touches the format-2 register or the strobe.
- Outside end strobes, the transfer registers hold.

The bench scenarios cover what needs known payloads:
- the nibble packing and fill;
- correction at every bit position;
- rejection on a double error or a missing byte;
- the raw format-1 capture;
- the priority between a commit and a field start in the same cycle.

// File: rtl/ttx_pkg.sv
package ttx_pkg;

    // Result of decoding one 8/4 codeword
    typedef struct packed {
        logic [3:0] msg;
        logic       bad;
    } ham_res_t;

    // Pass flags of the four odd-parity checks: {all, C, B, A}
    function automatic logic [3:0] ham_pass(input logic [7:0] c);
        ham_pass[0] = c[0] ^ c[1] ^ c[5] ^ c[7];
        ham_pass[1] = c[1] ^ c[2] ^ c[3] ^ c[7];
        ham_pass[2] = c[1] ^ c[3] ^ c[4] ^ c[5];
        ham_pass[3] = ^c;
    endfunction

endpackage

// File: rtl/ttx_ham84_dec.sv
module ttx_ham84_dec
    import ttx_pkg::*;
(
    input  logic [7:0] code_i,
    output ham_res_t   res_o
);

    logic [7:0] fixed_w;
    logic       found_w;

    // Find the codeword at distance 0 or 1 that satisfies every check
    always_comb begin
        fixed_w = code_i;
        found_w = &ham_pass(code_i);
        for (int j = 0; j < 8; j++) begin
            if (!found_w && (&ham_pass(code_i ^ (8'(1) << j)))) begin
                fixed_w = code_i ^ (8'(1) << j);
                found_w = 1'b1;
            end
        end
        res_o.bad = !found_w;
        res_o.msg = {fixed_w[7], fixed_w[5], fixed_w[3], fixed_w[1]};
    end

endmodule

// File: rtl/ttx_nib_pack.sv
module ttx_nib_pack #(
    parameter  int N_NIB  = 13,
    localparam int N_BYTE = (N_NIB + 1) / 2
) (
    input  logic [N_NIB*4-1:0]  nib_i,
    output logic [N_BYTE*8-1:0] byte_o
);

    // Nibble g lands in slot g: even slots are low halves, odd slots high halves
    for (genvar g = 0; g < N_BYTE * 2; g++) begin : g_slot
        if (g < N_NIB) begin : g_used
            assign byte_o[g*4 +: 4] = nib_i[g*4 +: 4];
        end else begin : g_fill
            assign byte_o[g*4 +: 4] = 4'hF;
        end
    end

endmodule

// File: rtl/ttx_pkt_extract.sv
module ttx_pkt_extract
    import ttx_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int F2_FIRST = 13,
    parameter int F2_COUNT = 13,
    parameter int F1_FIRST = 15,
    parameter int F1_COUNT = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            byte_valid,
    input  logic [IDX_W-1:0]                byte_idx,
    input  logic [7:0]                      byte_data,
    input  logic                            fmt2,
    input  logic                            pkt_end,
    input  logic                            bus_busy,
    input  logic                            field_start,
    output logic [8*((F2_COUNT+1)/2)-1:0]   f2_xfer,
    output logic [8*F1_COUNT-1:0]           f1_xfer,
    output logic                            davn_n
);

    localparam int F2_BYTES = (F2_COUNT + 1) / 2;
    localparam int F2_W     = 8 * F2_BYTES;
    localparam int F1_W     = 8 * F1_COUNT;

    typedef struct packed {
        logic [F2_COUNT-1:0][3:0] nib;
        logic [F2_COUNT-1:0]      f2_seen;
        logic                     f2_bad;
        logic [F1_COUNT-1:0][7:0] raw;
        logic [F1_COUNT-1:0]      f1_seen;
        logic [F2_W-1:0]          f2_out;
        logic [F1_W-1:0]          f1_out;
        logic                     davn_n;
    } st_t;

    st_t       st_d, st_q;
    ham_res_t  dec_w;
    logic [F2_W-1:0] packed_w;

    ttx_ham84_dec u_dec (
        .code_i (byte_data),
        .res_o  (dec_w)
    );

    ttx_nib_pack #(.N_NIB(F2_COUNT)) u_pack (
        .nib_i  (st_q.nib),
        .byte_o (packed_w)
    );

    always_comb begin
        st_d = st_q;
        if (field_start) begin
            st_d.davn_n = 1'b1;
        end
        if (pkt_end) begin
            if (fmt2) begin
                if ((&st_q.f2_seen) && !st_q.f2_bad && !bus_busy) begin
                    st_d.f2_out = packed_w;
                    st_d.davn_n = 1'b0;
                end
            end else if ((&st_q.f1_seen) && !bus_busy) begin
                st_d.f1_out = st_q.raw;
            end
            st_d.f2_seen = '0;
            st_d.f2_bad  = 1'b0;
            st_d.f1_seen = '0;
        end else if (byte_valid) begin
            if (fmt2) begin
                for (int k = 0; k < F2_COUNT; k++) begin
                    if (byte_idx == IDX_W'(F2_FIRST + k)) begin
                        st_d.nib[k]     = dec_w.msg;
                        st_d.f2_seen[k] = 1'b1;
                        st_d.f2_bad     = st_q.f2_bad | dec_w.bad;
                    end
                end
            end else begin
                for (int k = 0; k < F1_COUNT; k++) begin
                    if (byte_idx == IDX_W'(F1_FIRST + k)) begin
                        st_d.raw[k]     = byte_data;
                        st_d.f1_seen[k] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.f2_out <= '1;
            st_q.f1_out <= '1;
            st_q.davn_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign f2_xfer = st_q.f2_out;
    assign f1_xfer = st_q.f1_out;
    assign davn_n  = st_q.davn_n;

endmodule

// File: rtl/ttx_pkt_extract_chk.sv
module ttx_pkt_extract_chk #(
    parameter int F2W = 56,
    parameter int F1W = 56
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fmt2,
    input logic           pkt_end,
    input logic           bus_busy,
    input logic           field_start,
    input logic [F2W-1:0] f2_xfer,
    input logic [F1W-1:0] f1_xfer,
    input logic           davn_n
);

    // R6
    davn_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(davn_n) |-> $past(pkt_end && fmt2 && !bus_busy));

    // R7
    field_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && !pkt_end) |=> davn_n);

    // R8
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && bus_busy) |=> ($stable(f2_xfer) && $stable(f1_xfer) && !$fell(davn_n)));

    // R5
    fmt1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !fmt2) |=> ($stable(f2_xfer) && !$fell(davn_n)));

    // R10
    hold_between_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_end |=> ($stable(f2_xfer) && $stable(f1_xfer)));

endmodule

bind ttx_pkt_extract ttx_pkt_extract_chk #(
    .F2W (8 * ((F2_COUNT + 1) / 2)),
    .F1W (8 * F1_COUNT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt2        (fmt2),
    .pkt_end     (pkt_end),
    .bus_busy    (bus_busy),
    .field_start (field_start),
    .f2_xfer     (f2_xfer),
    .f1_xfer     (f1_xfer),
    .davn_n      (davn_n)
);

// File: tb/ttx_pkt_extract_test.sv
module ttx_pkt_extract_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [5:0]  byte_idx = '0;
    logic [7:0]  byte_data = '0;
    logic        fmt2 = 1'b0;
    logic        pkt_end = 1'b0;
    logic        bus_busy = 1'b0;
    logic        field_start = 1'b0;
    logic [55:0] f2_xfer;
    logic [55:0] f1_xfer;
    logic        davn_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [55:0] exp_f2, exp_f1;
    logic        exp_davn;

    always #10 clk = ~clk;

    ttx_pkt_extract uut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_idx(byte_idx),
        .byte_data(byte_data), .fmt2(fmt2), .pkt_end(pkt_end), .bus_busy(bus_busy),
        .field_start(field_start), .f2_xfer(f2_xfer), .f1_xfer(f1_xfer), .davn_n(davn_n)
    );

    function automatic logic [7:0] enc(input logic [3:0] n);
        logic [7:0] c;
        c[1] = n[0]; c[3] = n[1]; c[5] = n[2]; c[7] = n[3];
        c[0] = ~(n[0] ^ n[2] ^ n[3]);
        c[2] = ~(n[0] ^ n[1] ^ n[3]);
        c[4] = ~(n[0] ^ n[1] ^ n[2]);
        c[6] = 1'b0;
        c[6] = ~(^c);
        return c;
    endfunction

    function automatic logic [55:0] pack(input logic [51:0] n);
        logic [55:0] r;
        r = '1;
        for (int k = 0; k < 13; k++) r[(k/2)*8 + (k%2)*4 +: 4] = n[4*k +: 4];
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(f2_xfer == exp_f2, {tag, " f2_xfer"}, 64'(f2_xfer), 64'(exp_f2));
        chk(f1_xfer == exp_f1, {tag, " f1_xfer"}, 64'(f1_xfer), 64'(exp_f1));
        chk(davn_n == exp_davn, {tag, " davn_n"}, 64'(davn_n), 64'(exp_davn));
    endtask

    task automatic put_byte(input logic [5:0] idx, input logic [7:0] d);
        @(negedge clk);
        byte_valid = 1'b1; byte_idx = idx; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic end_line(input bit f2, input bit busy, input bit fs);
        @(negedge clk);
        fmt2 = f2; pkt_end = 1'b1; bus_busy = busy; field_start = fs;
        @(negedge clk);
        pkt_end = 1'b0; bus_busy = 1'b0; field_start = 1'b0;
    endtask

    task automatic pulse_field();
        @(negedge clk);
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        exp_davn = 1'b1;
    endtask

    // Sends a format-2 line; window bytes plus uncorrectable junk at 12 and 26
    task automatic send_f2(input logic [51:0] nibs, input int bad_k, input logic [7:0] bad_mask,
                           input int skip_k);
        logic [7:0] c;
        fmt2 = 1'b1;
        put_byte(6'd12, 8'h01);
        for (int k = 0; k < 13; k++) begin
            if (k != skip_k) begin
                c = enc(nibs[4*k +: 4]);
                if (k == bad_k) c = c ^ bad_mask;
                put_byte(6'(13 + k), c);
            end
        end
        put_byte(6'd26, 8'h01);
    endtask

    task automatic t_reset();
        exp_f2 = '1; exp_f1 = '1; exp_davn = 1'b1;
        check_all("R1 reset");
    endtask

    task automatic t_clean();
        logic [51:0] n = 52'h0123456789ABC;
        send_f2(n, -1, 8'h00, -1);
        check_all("R10 bytes before end");
        end_line(1'b1, 1'b0, 1'b0);
        exp_f2 = pack(n); exp_davn = 1'b0;
        check_all("R2 R6 R9 clean format-2 line");
        pulse_field();
        check_all("R7 field start releases");
    endtask

    task automatic t_single();
        for (int p = 0; p < 8; p++) begin
            logic [51:0] n = 52'hFEDCBA9876543 ^ {13{4'(p)}};
            send_f2(n, p + 3, 8'(1) << p, -1);
            end_line(1'b1, 1'b0, 1'b0);
            exp_f2 = pack(n); exp_davn = 1'b0;
            check_all($sformatf("R3 single error bit %0d", p));
            pulse_field();
        end
    endtask

    task automatic t_double();
        send_f2(52'h5A5A5A5A5A5A5, 6, 8'h05, -1);
        end_line(1'b1, 1'b0, 1'b0);
        check_all("R4 double error drops line");
    endtask

    task automatic t_fmt1();
        fmt2 = 1'b0;
        put_byte(6'd14, 8'hEE);
        for (int k = 0; k < 7; k++) put_byte(6'(15 + k), 8'(8'h3C + 17 * k));
        put_byte(6'd22, 8'hEE);
        end_line(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 7; k++) exp_f1[8*k +: 8] = 8'(8'h3C + 17 * k);
        check_all("R5 raw format-1 capture");
    endtask

    task automatic t_busy();
        send_f2(52'h1111122222333, -1, 8'h00, -1);
        end_line(1'b1, 1'b1, 1'b0);
        check_all("R8 busy blocks format-2");
        fmt2 = 1'b0;
        for (int k = 0; k < 7; k++) put_byte(6'(15 + k), 8'h77);
        end_line(1'b0, 1'b1, 1'b0);
        check_all("R8 busy blocks format-1");
    endtask

    task automatic t_missing();
        send_f2(52'h9999988888777, -1, 8'h00, 6);
        end_line(1'b1, 1'b0, 1'b0);
        check_all("R9 missing byte drops line");
    endtask

    task automatic t_same_cycle();
        logic [51:0] n = 52'h02468ACE13579;
        send_f2(n, -1, 8'h00, -1);
        end_line(1'b1, 1'b0, 1'b1);
        exp_f2 = pack(n); exp_davn = 1'b0;
        check_all("R7 commit beats field start");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_single();
        t_double();
        t_fmt1();
        t_busy();
        t_missing();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule